// File: doc/BRIEF.md
# DMA Channel Address and Count Register File

This block is the register file that a CPU sees for a four-channel DMA controller of the classic PC type. Each channel keeps a 16-bit base address and a 16-bit base count, which software loads one byte at a time over an 8-bit port. Alongside these, each channel keeps a live current address and a current transferred count. A single byte-pointer flip-flop, shared by all channels, decides whether an access reaches the low byte or the high byte. Every access then flips the pointer.

A completed high-byte write reloads the channel. The current address is reset from the base address and the transferred count goes back to zero. A read does not return the stored base values. It returns the live address (current address plus or minus the transferred count) and the remaining count (scaled base count minus the transferred count).

Two page registers per channel, a low one and a high one, extend the current address to a 31-bit physical address. The parameter `WSHIFT` selects the addressing mode: 0 for byte mode, 1 for word mode. In word mode the port decode, the stored current address, the read-back scaling and the transfer length all shift by one bit. A transfer engine picks a channel and receives its physical address, its transfer length and its direction. The engine writes back its progress through a count-update port.

Top module: `dma_chanreg_file`

## Requirements
- R1: The register index is bits [3:0] of `chan_port` shifted right by `WSHIFT`. When index bit 3 is 0, index bits [2:1] give the channel and index bit 0 selects the address register (0) or the count register (1). When index bit 3 is 1, the access is ignored: no register changes, the pointer does not move, and `chan_rdata` reads 0.
- R2: Any accepted channel access, whether `chan_wr` or `chan_rd`, uses the shared byte pointer and then flips it. Pointer 0 selects the low byte and pointer 1 selects the high byte.
- R3: A write with the pointer at 1 replaces bits [15:8] of the selected base register. On the next cycle that channel's current address equals its base address shifted left by `WSHIFT`, and its transferred count is 0.
- R4: A write with the pointer at 0 replaces bits [7:0] of the selected base register. It leaves the upper byte, the current address and the transferred count unchanged.
- R5: Reading the count register gives (base count << `WSHIFT`) minus the transferred count, modulo 2^(16+`WSHIFT`).
- R6: Reading the address register gives the current address plus the transferred count. When the channel's `dec_mode` bit is 1, it gives the current address minus the transferred count instead.
- R7: `chan_rdata` is the selected value shifted right by (`WSHIFT` + 8 × pointer), truncated to 8 bits.
- R8: `eng_len` equals (base count + 1) << `WSHIFT` for the channel selected by `eng_sel`.
- R9: `page_off` selects a page register. The values 7, 3, 1 and 2 select channels 0, 1, 2 and 3. `page_hi_sel` picks the high page (1) or the low page (0). Writes to any other offset are ignored, and reads at those offsets return 0.
- R10: `eng_phys_addr` places high page bits [6:0] at bits [30:24] and the low page at bits [23:16], then ORs in the current address of the channel selected by `eng_sel`.
- R11: `ptr_clr` forces the pointer to 0 on the next cycle. It wins over a channel access in the same cycle.
- R12: Synchronous reset clears every base, current and page register and sets the pointer to 0.
- R13: `eng_cnt_we` loads `eng_cnt` into the transferred count of channel `eng_sel`. A reloading high-byte write to the same channel in the same cycle takes priority.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ptr_clr | input | 1 | Clears the shared byte pointer |
| chan_wr | input | 1 | Channel register write strobe |
| chan_rd | input | 1 | Channel register read strobe |
| chan_port | input | 4+WSHIFT | Channel register port address |
| wdata | input | 8 | Write byte (channel and page ports) |
| chan_rdata | output | 8 | Read byte from the addressed channel register |
| page_wr | input | 1 | Page register write strobe |
| page_hi_sel | input | 1 | Selects the high page (1) or the low page (0) |
| page_off | input | 3 | Page port offset |
| page_rdata | output | 8 | Selected page register value |
| dec_mode | input | 4 | Decrement-direction flag, one bit per channel |
| eng_sel | input | 2 | Channel that the transfer engine is serving |
| eng_cnt_we | input | 1 | Transferred-count update strobe |
| eng_cnt | input | 16+WSHIFT | New transferred count |
| eng_phys_addr | output | 31 | Physical address of the selected channel |
| eng_len | output | 17+WSHIFT | Transfer length of the selected channel |
| eng_dec | output | 1 | Direction flag of the selected channel |

## Verification
The bench builds the block with `WSHIFT` = 1 (word mode), so every shift in the design is active. This covers the one-bit port decode, the 17-bit current address that reaches bit 16 of the physical address and overlaps the low page, the read-back byte taken from bits [8:1] or [16:9], and the doubled transfer length. Byte mode is the default, and the same model would compare it with the bench's shift constant set to 0. In word mode, the decrement and remaining-count arithmetic can wrap within the 17-bit field. Random engine counts drive that wrap, and the bench compares the result against the modular reference.

// File: rtl/dma_regs_pkg.sv
package dma_regs_pkg;

    localparam int NUM_CH  = 4;
    localparam int BYTE_W  = 8;
    localparam int BASE_W  = 16;
    localparam int PHYS_W  = 31;
    localparam int HPAGE_W = 7;

    typedef enum logic {
        PTR_LO = 1'b0,
        PTR_HI = 1'b1
    } byte_ptr_e;

    typedef enum logic {
        REG_ADDR = 1'b0,
        REG_CNT  = 1'b1
    } chan_reg_e;

    typedef struct packed {
        logic       hit;
        logic [1:0] ch;
    } page_hit_t;

    // Page port offset to channel: offsets 7,3,1,2 serve channels 0..3
    function automatic page_hit_t page_decode(input logic [2:0] off);
        page_hit_t r;
        r.hit = 1'b1;
        r.ch  = 2'd0;
        case (off)
            3'd7:    r.ch = 2'd0;
            3'd3:    r.ch = 2'd1;
            3'd1:    r.ch = 2'd2;
            3'd2:    r.ch = 2'd3;
            default: r.hit = 1'b0;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/dma_byte_ptr.sv
module dma_byte_ptr
    import dma_regs_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      clr,
    input  logic      step,
    output byte_ptr_e ptr
);

    always_ff @(posedge clk) begin
        if (rst || clr)
            ptr <= PTR_LO;
        else if (step)
            ptr <= (ptr == PTR_LO) ? PTR_HI : PTR_LO;
    end

    p_ptr_toggle_r2: assert property (@(posedge clk) disable iff (rst)
        (step && !clr) |=> (ptr != $past(ptr)));

    p_ptr_hold_r2: assert property (@(posedge clk) disable iff (rst)
        (!step && !clr) |=> $stable(ptr));

    p_ptr_clear_r11: assert property (@(posedge clk) disable iff (rst)
        clr |=> (ptr == PTR_LO));

    p_ptr_reset_r12: assert property (@(posedge clk)
        rst |=> (ptr == PTR_LO));

endmodule

// File: rtl/dma_chan_slot.sv
module dma_chan_slot
    import dma_regs_pkg::*;
#(
    parameter int WSHIFT = 0,
    localparam int CUR_W = BASE_W + WSHIFT
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                wr_en,
    input  logic                hi_byte,
    input  chan_reg_e           reg_sel,
    input  logic [BYTE_W-1:0]   wdata,
    input  logic                eng_we,
    input  logic [CUR_W-1:0]    eng_cnt,
    output logic [BASE_W-1:0]   base_addr,
    output logic [BASE_W-1:0]   base_cnt,
    output logic [CUR_W-1:0]    cur_addr,
    output logic [CUR_W-1:0]    cur_cnt
);

    logic [BASE_W-1:0] nxt_addr;
    logic [BASE_W-1:0] nxt_cnt;
    logic              reload;

    function automatic logic [BASE_W-1:0] merge_byte(
        input logic [BASE_W-1:0] old, input logic [BYTE_W-1:0] b, input logic hi);
        return hi ? {b, old[BYTE_W-1:0]} : {old[BASE_W-1:BYTE_W], b};
    endfunction

    always_comb begin
        nxt_addr = base_addr;
        nxt_cnt  = base_cnt;
        if (wr_en && reg_sel == REG_ADDR)
            nxt_addr = merge_byte(base_addr, wdata, hi_byte);
        if (wr_en && reg_sel == REG_CNT)
            nxt_cnt  = merge_byte(base_cnt, wdata, hi_byte);
        reload = wr_en && hi_byte;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            base_addr <= '0;
            base_cnt  <= '0;
            cur_addr  <= '0;
            cur_cnt   <= '0;
        end else begin
            base_addr <= nxt_addr;
            base_cnt  <= nxt_cnt;
            if (reload) begin
                cur_addr <= CUR_W'(nxt_addr) << WSHIFT;
                cur_cnt  <= '0;
            end else if (eng_we) begin
                cur_cnt  <= eng_cnt;
            end
        end
    end

    p_reload_cnt_r3: assert property (@(posedge clk) disable iff (rst)
        (wr_en && hi_byte) |=> (cur_cnt == '0));

    p_reload_addr_r3: assert property (@(posedge clk) disable iff (rst)
        (wr_en && hi_byte) |=> (cur_addr == (CUR_W'(base_addr) << WSHIFT)));

    p_low_keep_cur_r4: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !hi_byte && !eng_we) |=> ($stable(cur_addr) && $stable(cur_cnt)));

    p_low_keep_upper_r4: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !hi_byte) |=>
            (base_addr[BASE_W-1:BYTE_W] == $past(base_addr[BASE_W-1:BYTE_W]) &&
             base_cnt[BASE_W-1:BYTE_W]  == $past(base_cnt[BASE_W-1:BYTE_W])));

    p_eng_load_r13: assert property (@(posedge clk) disable iff (rst)
        (eng_we && !(wr_en && hi_byte)) |=> (cur_cnt == $past(eng_cnt)));

endmodule

// File: rtl/dma_page_regs.sv
module dma_page_regs
    import dma_regs_pkg::*;
(
    input  logic                           clk,
    input  logic                           rst,
    input  logic                           wr_en,
    input  logic                           hi_sel,
    input  logic [2:0]                     off,
    input  logic [BYTE_W-1:0]              wdata,
    output logic [BYTE_W-1:0]              rdata,
    output logic [NUM_CH-1:0][BYTE_W-1:0]  page_lo,
    output logic [NUM_CH-1:0][BYTE_W-1:0]  page_hi
);

    page_hit_t dec;

    always_comb begin
        dec = page_decode(off);
        if (!dec.hit)
            rdata = '0;
        else if (hi_sel)
            rdata = page_hi[dec.ch];
        else
            rdata = page_lo[dec.ch];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            page_lo <= '0;
            page_hi <= '0;
        end else if (wr_en && dec.hit) begin
            if (hi_sel)
                page_hi[dec.ch] <= wdata;
            else
                page_lo[dec.ch] <= wdata;
        end
    end

    p_page_miss_r9: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !dec.hit) |=> ($stable(page_lo) && $stable(page_hi)));

    p_page_idle_r9: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> ($stable(page_lo) && $stable(page_hi)));

endmodule

// File: rtl/dma_chanreg_file.sv
module dma_chanreg_file
    import dma_regs_pkg::*;
#(
    parameter int WSHIFT = 0
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   ptr_clr,
    input  logic                   chan_wr,
    input  logic                   chan_rd,
    input  logic [4+WSHIFT-1:0]    chan_port,
    input  logic [7:0]             wdata,
    output logic [7:0]             chan_rdata,
    input  logic                   page_wr,
    input  logic                   page_hi_sel,
    input  logic [2:0]             page_off,
    output logic [7:0]             page_rdata,
    input  logic [3:0]             dec_mode,
    input  logic [1:0]             eng_sel,
    input  logic                   eng_cnt_we,
    input  logic [16+WSHIFT-1:0]   eng_cnt,
    output logic [30:0]            eng_phys_addr,
    output logic [17+WSHIFT-1:0]   eng_len,
    output logic                   eng_dec
);

    localparam int CUR_W = BASE_W + WSHIFT;
    localparam int LEN_W = BASE_W + 1 + WSHIFT;

    logic [3:0]    idx;
    logic          idx_ok;
    logic [1:0]    ch;
    chan_reg_e     rsel;
    logic          access;
    byte_ptr_e     ptr;

    logic [NUM_CH-1:0][BASE_W-1:0] base_addr;
    logic [NUM_CH-1:0][BASE_W-1:0] base_cnt;
    logic [NUM_CH-1:0][CUR_W-1:0]  cur_addr;
    logic [NUM_CH-1:0][CUR_W-1:0]  cur_cnt;
    logic [NUM_CH-1:0][BYTE_W-1:0] page_lo;
    logic [NUM_CH-1:0][BYTE_W-1:0] page_hi;

    always_comb begin
        idx    = 4'(chan_port >> WSHIFT);
        idx_ok = !idx[3];
        ch     = idx[2:1];
        rsel   = chan_reg_e'(idx[0]);
        access = idx_ok && (chan_wr || chan_rd);
    end

    dma_byte_ptr u_ptr (
        .clk  (clk),
        .rst  (rst),
        .clr  (ptr_clr),
        .step (access),
        .ptr  (ptr)
    );

    for (genvar g = 0; g < NUM_CH; g++) begin : g_chan
        dma_chan_slot #(.WSHIFT(WSHIFT)) u_slot (
            .clk       (clk),
            .rst       (rst),
            .wr_en     (chan_wr && idx_ok && ch == 2'(g)),
            .hi_byte   (ptr == PTR_HI),
            .reg_sel   (rsel),
            .wdata     (wdata),
            .eng_we    (eng_cnt_we && eng_sel == 2'(g)),
            .eng_cnt   (eng_cnt),
            .base_addr (base_addr[g]),
            .base_cnt  (base_cnt[g]),
            .cur_addr  (cur_addr[g]),
            .cur_cnt   (cur_cnt[g])
        );
    end

    dma_page_regs u_page (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (page_wr),
        .hi_sel  (page_hi_sel),
        .off     (page_off),
        .wdata   (wdata),
        .rdata   (page_rdata),
        .page_lo (page_lo),
        .page_hi (page_hi)
    );

    // Live read-back: remaining count or moving address
    logic [CUR_W-1:0] left_cnt;
    logic [CUR_W-1:0] live_addr;
    logic [CUR_W-1:0] sel_val;
    int               shamt;

    always_comb begin
        left_cnt  = (CUR_W'(base_cnt[ch]) << WSHIFT) - cur_cnt[ch];
        live_addr = dec_mode[ch] ? (cur_addr[ch] - cur_cnt[ch])
                                 : (cur_addr[ch] + cur_cnt[ch]);
        sel_val   = (rsel == REG_CNT) ? left_cnt : live_addr;
        shamt     = WSHIFT + ((ptr == PTR_HI) ? BYTE_W : 0);
        chan_rdata = idx_ok ? BYTE_W'(sel_val >> shamt) : '0;
    end

    // Transfer engine view
    always_comb begin
        eng_phys_addr = {page_hi[eng_sel][HPAGE_W-1:0], page_lo[eng_sel], 16'h0000}
                      | PHYS_W'(cur_addr[eng_sel]);
        eng_len       = LEN_W'(({1'b0, base_cnt[eng_sel]} + 17'd1)) << WSHIFT;
        eng_dec       = dec_mode[eng_sel];
    end

    p_bad_index_ptr_r1: assert property (@(posedge clk) disable iff (rst)
        ((chan_wr || chan_rd) && !idx_ok && !ptr_clr) |=> $stable(ptr));

    p_bad_index_regs_r1: assert property (@(posedge clk) disable iff (rst)
        (chan_wr && !idx_ok && !eng_cnt_we) |=>
            ($stable(base_addr) && $stable(base_cnt) && $stable(cur_addr) && $stable(cur_cnt)));

    p_len_nonzero_r8: assert property (@(posedge clk) disable iff (rst)
        1'b1 |-> (eng_len != '0));

endmodule

// File: tb/sim_dma_chanreg_file.sv
module sim_dma_chanreg_file;

    localparam int WS = 1;
    localparam int CW = 16 + WS;
    localparam int LW = 17 + WS;
    localparam int PW = 4 + WS;

    logic          clk = 1'b0;
    logic          rst;
    logic          ptr_clr, chan_wr, chan_rd, page_wr, page_hi_sel, eng_cnt_we;
    logic [PW-1:0] chan_port;
    logic [7:0]    wdata, chan_rdata, page_rdata;
    logic [2:0]    page_off;
    logic [3:0]    dec_mode;
    logic [1:0]    eng_sel;
    logic [CW-1:0] eng_cnt;
    logic [30:0]   eng_phys_addr;
    logic [LW-1:0] eng_len;
    logic          eng_dec;

    always #10 clk = ~clk;

    dma_chanreg_file #(.WSHIFT(WS)) u0 (
        .clk(clk), .rst(rst), .ptr_clr(ptr_clr), .chan_wr(chan_wr), .chan_rd(chan_rd),
        .chan_port(chan_port), .wdata(wdata), .chan_rdata(chan_rdata),
        .page_wr(page_wr), .page_hi_sel(page_hi_sel), .page_off(page_off),
        .page_rdata(page_rdata), .dec_mode(dec_mode), .eng_sel(eng_sel),
        .eng_cnt_we(eng_cnt_we), .eng_cnt(eng_cnt), .eng_phys_addr(eng_phys_addr),
        .eng_len(eng_len), .eng_dec(eng_dec)
    );

    int errs = 0;
    int checks = 0;
    bit done = 0;
    int cmask = (1 << CW) - 1;
    int m_ba[4], m_bc[4], m_ca[4], m_cc[4], m_pl[4], m_ph[4];
    int m_ptr;

    function automatic int pmap(int off);
        case (off)
            7: return 0;
            3: return 1;
            1: return 2;
            2: return 3;
            default: return -1;
        endcase
    endfunction

    task automatic chk(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            errs++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic compare(string tag);
        int idx, ch, val, exp, c, e;
        idx = (int'(chan_port) >> WS) & 15;
        exp = 0;
        if (idx < 8) begin
            ch = idx >> 1;
            if (idx & 1)
                val = ((m_bc[ch] << WS) - m_cc[ch]) & cmask;
            else if (dec_mode[ch])
                val = (m_ca[ch] - m_cc[ch]) & cmask;
            else
                val = (m_ca[ch] + m_cc[ch]) & cmask;
            exp = (val >> (WS + 8 * m_ptr)) & 255;
        end
        chk(tag, int'(chan_rdata), exp);
        c = pmap(int'(page_off));
        chk("R9", int'(page_rdata), (c < 0) ? 0 : (page_hi_sel ? m_ph[c] : m_pl[c]));
        e = int'(eng_sel);
        chk("R10", int'(eng_phys_addr), ((m_ph[e] & 127) << 24) | (m_pl[e] << 16) | m_ca[e]);
        chk("R8", int'(eng_len), (m_bc[e] + 1) << WS);
        chk("R10", int'(eng_dec), int'(dec_mode[e]));
    endtask

    task automatic update();
        int idx, ch, rl, c;
        rl = -1;
        if (rst) begin
            for (int i = 0; i < 4; i++) begin
                m_ba[i] = 0; m_bc[i] = 0; m_ca[i] = 0; m_cc[i] = 0; m_pl[i] = 0; m_ph[i] = 0;
            end
            m_ptr = 0;
            return;
        end
        idx = (int'(chan_port) >> WS) & 15;
        ch  = (idx >> 1) & 3;
        if (idx < 8 && chan_wr) begin
            if (idx & 1) begin
                if (m_ptr == 1) m_bc[ch] = (m_bc[ch] & 255) | (int'(wdata) << 8);
                else            m_bc[ch] = (m_bc[ch] & 16'hff00) | int'(wdata);
            end else begin
                if (m_ptr == 1) m_ba[ch] = (m_ba[ch] & 255) | (int'(wdata) << 8);
                else            m_ba[ch] = (m_ba[ch] & 16'hff00) | int'(wdata);
            end
            if (m_ptr == 1) begin
                m_ca[ch] = (m_ba[ch] << WS) & cmask;
                m_cc[ch] = 0;
                rl = ch;
            end
        end
        if (eng_cnt_we && rl != int'(eng_sel))
            m_cc[eng_sel] = int'(eng_cnt);
        c = pmap(int'(page_off));
        if (page_wr && c >= 0) begin
            if (page_hi_sel) m_ph[c] = int'(wdata);
            else             m_pl[c] = int'(wdata);
        end
        if (ptr_clr)
            m_ptr = 0;
        else if (idx < 8 && (chan_wr || chan_rd))
            m_ptr = 1 - m_ptr;
    endtask

    task automatic cyc(string tag);
        #2;
        if (!rst) compare(tag);
        @(posedge clk);
        update();
        @(negedge clk);
    endtask

    task automatic idle();
        ptr_clr = 0; chan_wr = 0; chan_rd = 0; page_wr = 0; eng_cnt_we = 0;
    endtask

    task automatic acc(bit wr, int ch, int r, int data, string tag);
        chan_port = PW'((ch * 2 + r) << WS);
        wdata = 8'(data);
        chan_wr = wr; chan_rd = !wr;
        cyc(tag);
        idle();
    endtask

    initial begin
        rst = 1; idle();
        chan_port = '0; wdata = '0; page_hi_sel = 0; page_off = '0;
        dec_mode = '0; eng_sel = '0; eng_cnt = '0;
        for (int i = 0; i < 4; i++) begin
            m_ba[i] = 0; m_bc[i] = 0; m_ca[i] = 0; m_cc[i] = 0; m_pl[i] = 0; m_ph[i] = 0;
        end
        m_ptr = 0;
        @(negedge clk);
        repeat (3) cyc("R12");
        rst = 0;
        // R12: reset state visible at every port
        for (int c = 0; c < 4; c++) begin
            eng_sel = 2'(c);
            acc(0, c, c & 1, 0, "R12");
        end
        ptr_clr = 1; cyc("R11"); idle();
        // R4 then R3: low byte, then high byte with reload
        acc(1, 1, 0, 8'h34, "R4");
        acc(1, 1, 0, 8'h92, "R3");
        acc(1, 1, 1, 8'h0f, "R4");
        acc(1, 1, 1, 8'h01, "R3");
        eng_sel = 2'd1;
        acc(0, 1, 0, 0, "R6");
        acc(0, 1, 0, 0, "R7");
        // R13: engine progress, then live reads
        eng_cnt = CW'(5); eng_cnt_we = 1; cyc("R13"); idle();
        acc(0, 1, 1, 0, "R5");
        acc(0, 1, 1, 0, "R5");
        dec_mode = 4'b0010;
        acc(0, 1, 0, 0, "R6");
        acc(0, 1, 0, 0, "R6");
        // R4: low write leaves transfer state alone
        acc(1, 1, 0, 8'h77, "R4");
        acc(0, 1, 0, 0, "R4");
        acc(0, 1, 0, 0, "R4");
        // R1: upper-index ports ignored, pointer unchanged
        for (int k = 0; k < 8; k++) begin
            chan_port = PW'((8 + k) << WS); wdata = 8'hee; chan_wr = k[0]; chan_rd = !k[0];
            cyc("R1"); idle();
        end
        acc(0, 1, 0, 0, "R1");
        acc(0, 1, 0, 0, "R2");
        // R11: clear wins over simultaneous access
        acc(0, 1, 0, 0, "R2");
        chan_port = PW'(2 << WS); chan_rd = 1; ptr_clr = 1; cyc("R11"); idle();
        acc(0, 1, 0, 0, "R11");
        // R9: all page offsets, both halves
        for (int o = 0; o < 8; o++) begin
            for (int h = 0; h < 2; h++) begin
                page_off = 3'(o); page_hi_sel = h[0]; wdata = 8'(16 * o + 3 + 128 * h);
                page_wr = 1; cyc("R9"); idle(); cyc("R9");
            end
        end
        // R10: physical address for each channel, word-mode overlap at bit 16
        for (int c = 0; c < 4; c++) begin
            ptr_clr = 1; cyc("R11"); idle();
            acc(1, c, 0, 8'h10 + c, "R10");
            acc(1, c, 0, 8'hc0 + c, "R10");
            eng_sel = 2'(c); cyc("R10");
        end
        // R13: reload beats simultaneous engine write
        eng_sel = 2'd2; eng_cnt = CW'(99); eng_cnt_we = 1;
        chan_port = PW'((2 * 2 + 1) << WS); wdata = 8'h05; chan_wr = 1;
        cyc("R13"); idle();
        acc(0, 2, 1, 0, "R13");
        acc(0, 2, 1, 0, "R13");
        // R8: length corner with all-ones count
        ptr_clr = 1; cyc("R11"); idle();
        acc(1, 3, 1, 8'hff, "R8");
        acc(1, 3, 1, 8'hff, "R8");
        eng_sel = 2'd3; cyc("R8");
        // Random mix against the model
        for (int n = 0; n < 4000; n++) begin
            chan_port   = PW'($urandom);
            wdata       = 8'($urandom);
            chan_wr     = ($urandom % 4) == 0;
            chan_rd     = !chan_wr && (($urandom % 3) == 0);
            ptr_clr     = ($urandom % 9) == 0;
            page_wr     = ($urandom % 6) == 0;
            page_hi_sel = 1'($urandom);
            page_off    = 3'($urandom);
            dec_mode    = 4'($urandom);
            eng_sel     = 2'($urandom);
            eng_cnt_we  = ($urandom % 4) == 0;
            eng_cnt     = CW'($urandom);
            cyc("R7");
        end
        idle();
        done = 1;
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errs++; checks++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end

endmodule